// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Access Controller

This block is the control path and storage of a synchronous SRAM with registered inputs and a registered output. At each rising clock edge it decodes three chip enables and two address strobes. One strobe belongs to the processor and one to the controller. It also decodes a global write enable, a byte write enable and one select per byte lane, and from these it starts reads, starts writes or deselects the device. The word is 36 bits wide and split into four 9-bit lanes.

Read data goes through an output register. The output drivers are modelled as a drive-enable flag, `dq_drive`, placed next to the registered data. The output enable acts on that flag without a clock, as a plain gate. A write begun by the processor strobe finishes one clock after it starts. A write begun by the controller strobe happens on its own start edge. Address advance within a burst comes from outside, so a continuing access keeps using the address captured at its start.

Top module: `ssram_access_ctrl`

## Requirements
- R1: The device is selected when chip_en1_n=0, chip_en2=1 and chip_en3_n=0. A read starts at a rising edge when a strobe is low, the device is selected, and all_wr_n=1 and byte_wr_n=1. The word at the captured address appears on rdata with dq_drive=1 after the following rising edge, provided out_en_n=0.
- R2: Reads started on consecutive edges each deliver their own word on consecutive cycles, in the order they were started.
- R3: In the first cycle of an access that starts from the deselected state, dq_drive stays 0 even when out_en_n=0.
- R4: A strobe at an edge while the device is not selected deselects it, and dq_drive is 0 right after that edge.
- R5: A low cpu_strb_n is ignored while chip_en1_n=1. It neither starts nor ends an access.
- R6: For an access started by cpu_strb_n (which wins when both strobes are low), the write enables at the start edge are ignored. The write happens at the next edge, to the address captured at the start, whatever the address inputs then show.
- R7: For an access started by ctl_strb_n alone, the write enables are applied at the start edge, to the address presented at that edge.
- R8: all_wr_n=0 writes all four lanes, whatever byte_wr_n and lane_sel_n show.
- R9: With all_wr_n=1 and byte_wr_n=0, lane i (wdata bits 9i+8 down to 9i) is written only when lane_sel_n[i]=0.
- R10: out_en_n gates dq_drive without a clock. A change on out_en_n shows on dq_drive within the same cycle.
- R11: dq_drive is 0 in the cycle after any edge that performs a write.
- R12: While reset is high and after it is released, dq_drive is 0 until a read delivers data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chip_en1_n | input | 1 | Chip enable 1, active low; also qualifies cpu_strb_n |
| chip_en2 | input | 1 | Chip enable 2, active high |
| chip_en3_n | input | 1 | Chip enable 3, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| all_wr_n | input | 1 | Global write enable, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte select, active low |
| out_en_n | input | 1 | Output enable, active low, no clock |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Output register contents |
| dq_drive | output | 1 | Output drivers enabled |

## Verification
The bench uses the default build: 6 address bits (64 words) and four lanes of 9 bits. Sixty-four words are enough to keep a handful of addresses apart, so a write that is ignored, or that goes to the wrong address, shows up when that address is read back later. Nine-bit lanes with patterns that differ per lane make a stray or missing lane write visible in a single compare. The short pipeline puts the tri-state cases from R3, R4 and R11 only one cycle from their trigger edges.

// File: rtl/ssram_ctrl_pkg.sv
package ssram_ctrl_pkg;
  // Per-edge command decoded from strobes and chip enables
  typedef enum logic [1:0] {
    CMD_HOLD    = 2'd0,  // no qualified strobe: continue or stay idle
    CMD_DESEL   = 2'd1,  // strobe with device not selected
    CMD_START_P = 2'd2,  // processor strobe start
    CMD_START_C = 2'd3   // controller strobe start
  } cmd_e;
endpackage

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode
  import ssram_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             chip_en1_n,
  input  logic             chip_en2,
  input  logic             chip_en3_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cmd_e             cmd,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_ok
);
  logic selected;
  logic p_go;
  logic c_go;

  assign selected = !chip_en1_n && chip_en2 && !chip_en3_n;
  assign p_go     = !cpu_strb_n && !chip_en1_n;  // processor strobe needs enable 1
  assign c_go     = !ctl_strb_n;

  always_comb begin
    if (p_go || c_go) begin
      if (!selected)  cmd = CMD_DESEL;
      else if (p_go)  cmd = CMD_START_P;
      else            cmd = CMD_START_C;
    end else begin
      cmd = CMD_HOLD;
    end
  end

  always_comb begin
    if (!all_wr_n)       wr_mask = '1;
    else if (!byte_wr_n) wr_mask = ~lane_sel_n;
    else                 wr_mask = '0;
  end

  assign rd_ok = all_wr_n && byte_wr_n;
endmodule

// File: rtl/ssram_access_seq.sv
module ssram_access_seq
  import ssram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_e              cmd,
  input  logic [LANES-1:0]  wr_mask,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              rd_pend,
  output logic              wr_now,
  output logic              out_clr
);
  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic              active_d;
  logic [ADDR_W-1:0] addr_d;
  logic              rd_pend_d;

  always_comb begin
    mem_we    = '0;
    mem_waddr = addr_q;
    active_d  = active_q;
    addr_d    = addr_q;
    rd_pend_d = 1'b0;
    out_clr   = 1'b0;
    unique case (cmd)
      CMD_START_P: begin
        active_d  = 1'b1;
        addr_d    = addr;
        rd_pend_d = 1'b1;           // write inputs ignored at this edge
      end
      CMD_START_C: begin
        active_d  = 1'b1;
        addr_d    = addr;
        mem_we    = wr_mask;
        mem_waddr = addr;
        rd_pend_d = rd_ok;
      end
      CMD_DESEL: begin
        active_d  = 1'b0;
        out_clr   = 1'b1;
      end
      default: begin
        if (active_q) begin
          mem_we    = wr_mask;
          rd_pend_d = rd_ok;
        end
      end
    endcase
  end

  assign wr_now    = |mem_we;
  assign mem_raddr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      rd_pend  <= 1'b0;
    end else begin
      active_q <= active_d;
      addr_q   <= addr_d;
      rd_pend  <= rd_pend_d;
    end
  end
endmodule

// File: rtl/ssram_lane_array.sv
module ssram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    // read-first output register
    always_ff @(posedge clk) begin
      if (rd_en) rd_q <= mem[raddr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic out_clr,
  input  logic rd_pend,
  input  logic wr_now,
  input  logic out_en_n,
  output logic dq_drive
);
  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst || out_clr) valid_q <= 1'b0;
    else                valid_q <= rd_pend && !wr_now;
  end

  assign dq_drive = valid_q && !out_en_n;
endmodule

// File: rtl/ssram_access_ctrl.sv
module ssram_access_ctrl
  import ssram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en1_n,
  input  logic              chip_en2,
  input  logic              chip_en3_n,
  input  logic              cpu_strb_n,
  input  logic              ctl_strb_n,
  input  logic              all_wr_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dq_drive
);
  cmd_e              cmd;
  logic [LANES-1:0]  wr_mask;
  logic              rd_ok;
  logic [LANES-1:0]  mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ADDR_W-1:0] mem_raddr;
  logic              rd_pend;
  logic              wr_now;
  logic              out_clr;

  ssram_cmd_decode #(.LANES(LANES)) u_dec (
    .chip_en1_n (chip_en1_n),
    .chip_en2   (chip_en2),
    .chip_en3_n (chip_en3_n),
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .all_wr_n   (all_wr_n),
    .byte_wr_n  (byte_wr_n),
    .lane_sel_n (lane_sel_n),
    .cmd        (cmd),
    .wr_mask    (wr_mask),
    .rd_ok      (rd_ok)
  );

  ssram_access_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .wr_mask   (wr_mask),
    .rd_ok     (rd_ok),
    .addr      (addr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_raddr (mem_raddr),
    .rd_pend   (rd_pend),
    .wr_now    (wr_now),
    .out_clr   (out_clr)
  );

  ssram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wdata),
    .rd_en (rd_pend),
    .raddr (mem_raddr),
    .rdata (rdata)
  );

  ssram_out_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .out_clr  (out_clr),
    .rd_pend  (rd_pend),
    .wr_now   (wr_now),
    .out_en_n (out_en_n),
    .dq_drive (dq_drive)
  );
endmodule

// File: rtl/ssram_access_ctrl_chk.sv
module ssram_access_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             chip_en1_n,
  input logic             chip_en2,
  input logic             chip_en3_n,
  input logic             cpu_strb_n,
  input logic             ctl_strb_n,
  input logic             all_wr_n,
  input logic             byte_wr_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             out_en_n,
  input logic             dq_drive
);
  logic sel, p_go, c_go, any_go, wr_req, idle_q;

  assign sel    = !chip_en1_n && chip_en2 && !chip_en3_n;
  assign p_go   = !cpu_strb_n && !chip_en1_n;
  assign c_go   = !ctl_strb_n;
  assign any_go = p_go || c_go;
  assign wr_req = !all_wr_n || (!byte_wr_n && (lane_sel_n != '1));

  always_ff @(posedge clk) begin
    if (rst)                 idle_q <= 1'b1;
    else if (any_go && !sel) idle_q <= 1'b1;
    else if (any_go)         idle_q <= 1'b0;
  end

  p_reset_quiet_r12: assert property (@(posedge clk) rst |=> !dq_drive);

  p_desel_off_r4: assert property (@(posedge clk) disable iff (rst)
    (any_go && !sel) |=> !dq_drive);

  p_emerge_off_r3: assert property (@(posedge clk) disable iff (rst)
    (idle_q && any_go && sel) |=> !dq_drive);

  p_write_off_r11: assert property (@(posedge clk) disable iff (rst)
    (c_go && !p_go && sel && wr_req) |=> !dq_drive);

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !dq_drive);
endmodule

bind ssram_access_ctrl ssram_access_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_en1_n (chip_en1_n),
  .chip_en2   (chip_en2),
  .chip_en3_n (chip_en3_n),
  .cpu_strb_n (cpu_strb_n),
  .ctl_strb_n (ctl_strb_n),
  .all_wr_n   (all_wr_n),
  .byte_wr_n  (byte_wr_n),
  .lane_sel_n (lane_sel_n),
  .out_en_n   (out_en_n),
  .dq_drive   (dq_drive)
);

// File: tb/ssram_access_ctrl_test.sv
module ssram_access_ctrl_test;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          c1n = 1'b0, c2 = 1'b1, c3n = 1'b0;
  logic          pn = 1'b1, cn = 1'b1, gn = 1'b1, bn = 1'b1;
  logic [NL-1:0] lsn = '1;
  logic          oen = 1'b0;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd;
  logic          drv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [1<<AW];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  ssram_access_ctrl #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst(rst), .chip_en1_n(c1n), .chip_en2(c2), .chip_en3_n(c3n),
    .cpu_strb_n(pn), .ctl_strb_n(cn), .all_wr_n(gn), .byte_wr_n(bn),
    .lane_sel_n(lsn), .out_en_n(oen), .addr(a), .wdata(wd),
    .rdata(rd), .dq_drive(drv)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // apply one cycle of inputs at the falling edge
  task automatic drive(input logic i_c1n, input logic i_c2, input logic i_c3n,
                       input logic i_pn, input logic i_cn, input logic i_gn,
                       input logic i_bn, input logic [NL-1:0] i_ls,
                       input logic [AW-1:0] i_a, input logic [DW-1:0] i_d);
    @(negedge clk);
    c1n = i_c1n; c2 = i_c2; c3n = i_c3n; pn = i_pn; cn = i_cn;
    gn = i_gn; bn = i_bn; lsn = i_ls; a = i_a; wd = i_d;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #5;
  endtask

  task automatic desel();
    drive(0, 0, 0, 1, 0, 1, 1, '1, '0, '0);
  endtask

  task automatic cont(input logic gwn, input logic [DW-1:0] d);
    drive(0, 1, 0, 1, 1, gwn, 1, '1, 6'd33, d);
  endtask

  function automatic void model_wr(input logic [AW-1:0] ad, input logic [DW-1:0] d,
                                   input logic [NL-1:0] m);
    for (int i = 0; i < NL; i++)
      if (m[i]) model[ad][i*LW +: LW] = d[i*LW +: LW];
  endfunction

  function automatic void expect_rd(input logic [AW-1:0] ad, input string t);
    exp_q.push_back(model[ad]);
    tag_q.push_back(t);
  endfunction

  // monitor: every driven output word is compared with the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && drv) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected drive", rd, '0);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd === e, t, rd, e);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R12 reset
    repeat (3) @(posedge clk);
    #5 chk(drv == 1'b0, "R12 in reset", {35'd0, drv}, '0);
    @(negedge clk) rst = 1'b0;
    after_edge();
    chk(drv == 1'b0, "R12 after reset", {35'd0, drv}, '0);

    // R7 R8: controller-strobe global write, lane selects all off
    drive(0, 1, 0, 1, 0, 0, 1, 4'hF, 6'd5, 36'h1_2345_6789);
    model_wr(6'd5, 36'h1_2345_6789, 4'hF);
    after_edge();
    chk(drv == 1'b0, "R11 after ctl write", {35'd0, drv}, '0);
    desel();

    // R9: byte write lanes 0 and 2 only
    drive(0, 1, 0, 1, 0, 1, 0, 4'b1010, 6'd5, 36'hA_BCDE_F012);
    model_wr(6'd5, 36'hA_BCDE_F012, 4'b0101);
    desel();

    // R6: processor start ignores write enables; write next edge at held addr
    drive(0, 1, 0, 0, 1, 0, 1, 4'hF, 6'd9, 36'hF_FFFF_FFFF);
    drive(0, 1, 0, 1, 1, 0, 1, 4'hF, 6'd20, 36'h3_3333_3333);
    model_wr(6'd9, 36'h3_3333_3333, 4'hF);
    after_edge();
    chk(drv == 1'b0, "R11 after cpu write", {35'd0, drv}, '0);
    desel();

    // setup addr 12, then processor start with write enable low must not write
    drive(0, 1, 0, 1, 0, 0, 1, 4'hF, 6'd12, 36'h0_5A5A_5A5A);
    model_wr(6'd12, 36'h0_5A5A_5A5A, 4'hF);
    desel();
    drive(0, 1, 0, 0, 1, 0, 1, 4'h0, 6'd12, 36'h7_7777_7777);
    expect_rd(6'd12, "R6 start write ignored");
    cont(1, '0);
    desel();
    after_edge();
    chk(drv == 1'b0, "R4 desel off", {35'd0, drv}, '0);

    // R1 R3 R9: read addr 5 from deselect
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd5, '0);
    expect_rd(6'd5, "R9 byte lanes read back");
    after_edge();
    chk(drv == 1'b0, "R3 first cycle off", {35'd0, drv}, '0);
    cont(1, '0);
    after_edge();
    chk(drv == 1'b1, "R1 data driven", {35'd0, drv}, 36'd1);
    desel();

    // R2: back-to-back processor reads
    drive(0, 1, 0, 0, 1, 1, 1, '1, 6'd9, '0);
    expect_rd(6'd9, "R2 b2b first");
    drive(0, 1, 0, 0, 1, 1, 1, '1, 6'd5, '0);
    expect_rd(6'd5, "R2 b2b second");
    drive(0, 1, 0, 0, 1, 1, 1, '1, 6'd12, '0);
    expect_rd(6'd12, "R2 b2b third");
    cont(1, '0);
    desel();
    after_edge();
    chk(drv == 1'b0, "R4 desel after b2b", {35'd0, drv}, '0);

    // R5: ignored processor strobe while active
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd5, '0);
    expect_rd(6'd5, "R5 read continues");
    drive(1, 1, 0, 0, 1, 1, 1, '1, 6'd33, '0);
    after_edge();
    chk(drv == 1'b1, "R5 no deselect", {35'd0, drv}, 36'd1);
    desel();
    // R5: ignored processor strobe while deselected
    drive(1, 1, 0, 0, 1, 1, 1, '1, 6'd5, '0);
    after_edge();
    chk(drv == 1'b0, "R5 no start edge", {35'd0, drv}, '0);
    drive(1, 1, 0, 1, 1, 1, 1, '1, 6'd5, '0);
    after_edge();
    chk(drv == 1'b0, "R5 no start next", {35'd0, drv}, '0);

    // R10: asynchronous output enable
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd9, '0);
    expect_rd(6'd9, "R10 read");
    cont(1, '0);
    @(posedge clk);
    #6 oen = 1'b1;
    #1 chk(drv == 1'b0, "R10 oe high", {35'd0, drv}, '0);
    oen = 1'b0;
    #1 chk(drv == 1'b1, "R10 oe low", {35'd0, drv}, 36'd1);
    desel();

    // R11 R7: controller write right after a read start
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd9, '0);
    drive(0, 1, 0, 1, 0, 0, 1, '1, 6'd20, 36'h9_8765_4321);
    model_wr(6'd20, 36'h9_8765_4321, 4'hF);
    after_edge();
    chk(drv == 1'b0, "R11 write kills read", {35'd0, drv}, '0);
    desel();
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd20, '0);
    expect_rd(6'd20, "R7 ctl write read back");
    cont(1, '0);
    desel();
    drive(0, 1, 0, 1, 0, 1, 1, '1, 6'd9, '0);
    expect_rd(6'd9, "R6 held address write");
    cont(1, '0);
    desel();

    repeat (3) after_edge();
    chk(exp_q.size() == 0, "R1 all reads delivered", 36'(exp_q.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule